// File: doc/BRIEF.md
# Enable Bitmap Range Coalescer

This block turns a 32-bit map of address-window enables into a short list of merged address ranges. A start strobe captures a bitmap and a mask, and their bitwise AND is kept. The engine then visits one bit position per clock, beginning at the most significant bit. Position `p` refers to bitmap bit `31-p`.

Every set position names one window. The low positions name 16 MB windows in the top 256 MB of the address space. The higher positions name 256 MB windows that start at address zero. When a window begins on the byte right after the end of the range being built, that range grows to cover it. Otherwise the window opens a new range in the next free slot.

There are three range slots. If a window needs a fourth range, the scan stops and raises an overflow flag. In normal use the mask is `0x003FFFFF`. That setting drops the fine windows below `0xFA000000` and keeps all the coarse windows. Software or a bring-up sequencer can read the resulting ranges as memory apertures.

Top module: `range_coalescer`

## Requirements
- R1: When a scan starts, the engine keeps `bitmap_i & mask_i`. A bitmap bit whose mask bit is 0 contributes no window.
- R2: Positions 0 to 15 (bitmap bits 31 down to 16) map to the window `0xF0000000 + p*0x01000000` through `0xF0000000 + p*0x01000000 + 0x00FFFFFF`.
- R3: Positions 16 to 30 (bitmap bits 15 down to 1) map to the window `(p-16)*0x10000000` through `(p-16)*0x10000000 + 0x0FFFFFFF`.
- R4: A window whose start equals the current range's end plus one moves that range's end to the window's end. The range keeps its slot and no new slot opens.
- R5: Any other set position opens a new range. Slots fill in scan order, slot 0 first. The first set position always opens slot 0, and a valid slot never follows an invalid one.
- R6: A window that would need a fourth range stops the scan. The engine then raises `overflow_o`, keeps the three ranges already built, and holds the flag until the next accepted start.
- R7: Position 31 (bitmap bit 0) is never turned into a window.
- R8: The scan covers positions 0 to 30 at one position per clock. `done_o` is high for exactly one cycle. With the accepting edge counted as edge 0, that cycle follows edge 31, or follows edge `p+1` when position `p` causes an overflow.
- R9: A start strobe that arrives while a scan is running has no effect on that scan's ranges, flag or timing.
- R10: An accepted start clears all slots to invalid with zero start and end, and clears `overflow_o`, from the next cycle on. Slots that are never opened stay invalid and zero.
- R11: After reset, all slots are invalid and zero, and `done_o` and `overflow_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted only when no scan is running |
| bitmap_i | input | 32 | Window enable map, sampled on an accepted start |
| mask_i | input | 32 | Mask ANDed with the bitmap on an accepted start |
| range_valid_o | output | 3 | Bit k set when slot k holds a range |
| range_lo_o | output | 96 | Slot start addresses, slot k in bits 32k+31:32k |
| range_hi_o | output | 96 | Slot end addresses (inclusive), same packing |
| done_o | output | 1 | One-cycle pulse at the end of a scan |
| overflow_o | output | 1 | A fourth range was needed; the scan stopped early |

## Verification
The assertions check structural properties on every cycle:
- the valid slots are packed from slot 0;
- unopened slots read zero;
- each range ends at or above its start;
- an overflow implies all three slots are full;
- `done_o` never lasts two cycles;
- an accepted start clears the outputs.

The bench's scenarios are the only way to show the address arithmetic of both window sizes, merging across neighbouring windows, the exact cycle of `done_o`, the early stop on overflow, the effect of the mask and of bit 0, and that a strobe during a scan leaves its result untouched.

// File: rtl/rc_pkg.sv
package rc_pkg;

    localparam int unsigned ADDR_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        addr_t lo;
        addr_t hi;
    } span_t;

endpackage

// File: rtl/rc_window_map.sv
module rc_window_map
    import rc_pkg::*;
#(
    parameter int unsigned POS_W        = 5,
    parameter int unsigned NFINE        = 16,
    parameter int unsigned FINE_SHIFT   = 24,
    parameter int unsigned COARSE_SHIFT = 28,
    parameter addr_t       FINE_BASE    = 32'hF000_0000
) (
    input  logic [POS_W-1:0] pos_i,
    output addr_t            lo_o,
    output addr_t            hi_o
);

    localparam addr_t FINE_SPAN   = (addr_t'(1) << FINE_SHIFT) - addr_t'(1);
    localparam addr_t COARSE_SPAN = (addr_t'(1) << COARSE_SHIFT) - addr_t'(1);

    addr_t lo_d;
    addr_t hi_d;

    always_comb begin
        if (pos_i < POS_W'(NFINE)) begin
            lo_d = FINE_BASE | (addr_t'(pos_i) << FINE_SHIFT);
            hi_d = lo_d + FINE_SPAN;
        end else begin
            lo_d = addr_t'(pos_i - POS_W'(NFINE)) << COARSE_SHIFT;
            hi_d = lo_d + COARSE_SPAN;
        end
    end

    assign lo_o = lo_d;
    assign hi_o = hi_d;

endmodule

// File: rtl/rc_range_bank.sv
module rc_range_bank
    import rc_pkg::*;
#(
    parameter int unsigned NSLOT = 3,
    parameter int unsigned CNT_W = $clog2(NSLOT + 1)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   clear_i,
    input  logic                   open_i,
    input  logic                   extend_i,
    input  addr_t                  lo_i,
    input  addr_t                  hi_i,
    output span_t [NSLOT-1:0]      slot_o,
    output logic  [NSLOT-1:0]      valid_o,
    output logic  [CNT_W-1:0]      count_o,
    output logic  [ADDR_W:0]       next_o
);

    typedef struct packed {
        span_t [NSLOT-1:0] slot;
        logic  [NSLOT-1:0] valid;
        logic  [CNT_W-1:0] cnt;
        logic  [ADDR_W:0]  nxt;
    } bank_s;

    bank_s bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (clear_i) begin
            bank_d = '0;
        end else if (open_i) begin
            for (int k = 0; k < NSLOT; k++) begin
                if (bank_q.cnt == CNT_W'(k)) begin
                    bank_d.slot[k].lo = lo_i;
                    bank_d.slot[k].hi = hi_i;
                    bank_d.valid[k]   = 1'b1;
                end
            end
            bank_d.cnt = bank_q.cnt + CNT_W'(1);
            bank_d.nxt = {1'b0, hi_i} + (ADDR_W+1)'(1);
        end else if (extend_i) begin
            for (int k = 0; k < NSLOT; k++) begin
                if (bank_q.cnt == CNT_W'(k + 1)) begin
                    bank_d.slot[k].hi = hi_i;
                end
            end
            bank_d.nxt = {1'b0, hi_i} + (ADDR_W+1)'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bank_q <= '0;
        else         bank_q <= bank_d;
    end

    assign slot_o  = bank_q.slot;
    assign valid_o = bank_q.valid;
    assign count_o = bank_q.cnt;
    assign next_o  = bank_q.nxt;

    // R6: a slot is only ever opened while a free one remains
    p_open_has_room_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (open_i && !clear_i) |-> (bank_q.cnt < CNT_W'(NSLOT)));

    // R4: merging needs an open range to grow
    p_extend_needs_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (extend_i && !clear_i) |-> (bank_q.valid != '0));

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot_chk
        // R10: an unopened slot reads zero
        p_unopened_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !bank_q.valid[k] |-> (bank_q.slot[k] == '0));
        // R4: a range never ends below its start
        p_span_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            bank_q.valid[k] |-> (bank_q.slot[k].hi >= bank_q.slot[k].lo));
        if (k > 0) begin : g_pack
            // R5: slots fill from slot 0 upward
            p_valid_packed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
                bank_q.valid[k] |-> bank_q.valid[k-1]);
        end
    end

endmodule

// File: rtl/range_coalescer.sv
module range_coalescer
    import rc_pkg::*;
#(
    parameter int unsigned NPOS         = 32,
    parameter int unsigned NFINE        = 16,
    parameter int unsigned NSLOT        = 3,
    parameter int unsigned FINE_SHIFT   = 24,
    parameter int unsigned COARSE_SHIFT = 28,
    parameter addr_t       FINE_BASE    = 32'hF000_0000
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    start_i,
    input  logic [NPOS-1:0]         bitmap_i,
    input  logic [NPOS-1:0]         mask_i,
    output logic [NSLOT-1:0]        range_valid_o,
    output logic [NSLOT*ADDR_W-1:0] range_lo_o,
    output logic [NSLOT*ADDR_W-1:0] range_hi_o,
    output logic                    done_o,
    output logic                    overflow_o
);

    localparam int unsigned POS_W    = $clog2(NPOS);
    localparam int unsigned CNT_W    = $clog2(NSLOT + 1);
    localparam int unsigned LAST_POS = NPOS - 2;

    typedef struct packed {
        logic             busy;
        logic [POS_W-1:0] pos;
        logic [NPOS-1:0]  bits;
        logic             done;
        logic             ovf;
    } scan_s;

    scan_s scan_d, scan_q;

    addr_t             win_lo, win_hi;
    span_t [NSLOT-1:0] slots;
    logic  [NSLOT-1:0] valid;
    logic  [CNT_W-1:0] count;
    logic  [ADDR_W:0]  next_addr;

    logic accept, want, hit, do_open, do_extend, do_ovf;

    rc_window_map #(
        .POS_W        (POS_W),
        .NFINE        (NFINE),
        .FINE_SHIFT   (FINE_SHIFT),
        .COARSE_SHIFT (COARSE_SHIFT),
        .FINE_BASE    (FINE_BASE)
    ) u_map (
        .pos_i (scan_q.pos),
        .lo_o  (win_lo),
        .hi_o  (win_hi)
    );

    rc_range_bank #(
        .NSLOT (NSLOT),
        .CNT_W (CNT_W)
    ) u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (accept),
        .open_i   (do_open),
        .extend_i (do_extend),
        .lo_i     (win_lo),
        .hi_i     (win_hi),
        .slot_o   (slots),
        .valid_o  (valid),
        .count_o  (count),
        .next_o   (next_addr)
    );

    always_comb begin
        accept    = start_i && !scan_q.busy;
        want      = scan_q.busy && scan_q.bits[NPOS-1];
        hit       = (count != '0) && ({1'b0, win_lo} == next_addr);
        do_extend = want && hit;
        do_open   = want && !hit && (count < CNT_W'(NSLOT));
        do_ovf    = want && !hit && (count == CNT_W'(NSLOT));

        scan_d      = scan_q;
        scan_d.done = 1'b0;
        if (accept) begin
            scan_d.busy = 1'b1;
            scan_d.pos  = '0;
            scan_d.bits = bitmap_i & mask_i;
            scan_d.ovf  = 1'b0;
        end else if (scan_q.busy) begin
            if (do_ovf) begin
                scan_d.busy = 1'b0;
                scan_d.done = 1'b1;
                scan_d.ovf  = 1'b1;
            end else if (scan_q.pos == POS_W'(LAST_POS)) begin
                scan_d.busy = 1'b0;
                scan_d.done = 1'b1;
            end else begin
                scan_d.pos  = scan_q.pos + POS_W'(1);
                scan_d.bits = scan_q.bits << 1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) scan_q <= '0;
        else         scan_q <= scan_d;
    end

    for (genvar k = 0; k < NSLOT; k++) begin : g_out
        assign range_lo_o[k*ADDR_W +: ADDR_W] = slots[k].lo;
        assign range_hi_o[k*ADDR_W +: ADDR_W] = slots[k].hi;
    end

    assign range_valid_o = valid;
    assign done_o        = scan_q.done;
    assign overflow_o    = scan_q.ovf;

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R6: the overflow flag only appears with every slot taken
    p_overflow_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overflow_o |-> (&range_valid_o));

    // R10: an accepted start empties the result before the first position
    p_clear_on_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !scan_q.busy) |=> (range_valid_o == '0 && !overflow_o));

    // R9: a strobe during a scan does not restart the position count
    p_busy_strobe_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scan_q.busy && start_i && scan_q.pos != POS_W'(LAST_POS) && !do_ovf)
            |=> (scan_q.pos == $past(scan_q.pos) + POS_W'(1)));

endmodule

// File: tb/range_coalescer_test.sv
`timescale 1ns/1ps
module range_coalescer_test;

    typedef struct packed {
        logic [2:0]       v;
        logic [2:0][31:0] lo;
        logic [2:0][31:0] hi;
        logic             ovf;
        logic [7:0]       lat;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] bitmap = '0;
    logic [31:0] mask = '0;
    logic [2:0]  valid;
    logic [95:0] lo_flat, hi_flat;
    logic        done, ovf;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    exp_t  exp_q[$];
    int    cyc_q[$];
    string tag_q[$];

    range_coalescer uut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .start_i       (start),
        .bitmap_i      (bitmap),
        .mask_i        (mask),
        .range_valid_o (valid),
        .range_lo_o    (lo_flat),
        .range_hi_o    (hi_flat),
        .done_o        (done),
        .overflow_o    (ovf)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic exp_t model(logic [31:0] bm, logic [31:0] mk);
        exp_t e;
        logic [32:0] nxt;
        logic [31:0] m;
        int n;
        e = '0; n = 0; nxt = '0; m = bm & mk; e.lat = 8'd31;
        for (int i = 0; i < 31; i++) begin
            logic [31:0] b, t;
            if (!m[31-i]) continue;
            if (i < 16) begin
                b = 32'hF000_0000 + 32'(i) * 32'h0100_0000;
                t = b + 32'h00FF_FFFF;
            end else begin
                b = 32'(i - 16) * 32'h1000_0000;
                t = b + 32'h0FFF_FFFF;
            end
            if (n > 0 && {1'b0, b} == nxt) begin
                e.hi[n-1] = t;
            end else if (n == 3) begin
                e.ovf = 1'b1;
                e.lat = 8'(i + 1);
                break;
            end else begin
                e.lo[n] = b; e.hi[n] = t; e.v[n] = 1'b1;
                n++;
            end
            nxt = {1'b0, t} + 33'd1;
        end
        return e;
    endfunction

    // driver: starts a scan and queues what the monitor must see
    task automatic run_scan(logic [31:0] bm, logic [31:0] mk, string tag,
                            bit intrude = 0, logic [31:0] other = '0);
        exp_t e;
        @(negedge clk);
        start = 1'b1; bitmap = bm; mask = mk;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(valid == 3'b000 && !ovf && lo_flat == '0 && hi_flat == '0,
              "R10", "outputs cleared after start", {valid, ovf}, 64'h0);
        e = model(bm, mk);
        exp_q.push_back(e);
        cyc_q.push_back(cyc + int'(e.lat));
        tag_q.push_back(tag);
        if (intrude) begin
            repeat (5) @(negedge clk);
            start = 1'b1; bitmap = other; mask = 32'hFFFF_FFFF;
            @(negedge clk);
            start = 1'b0;
        end
        wait (exp_q.size() == 0);
        repeat (3) @(negedge clk);
    endtask

    // monitor: compares each finished scan against the queued expectation
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9", "unexpected done pulse", 64'd1, 64'd0);
                end else begin
                    exp_t  e;
                    int    c;
                    string tg;
                    e = exp_q[0]; c = cyc_q.pop_front(); tg = tag_q.pop_front();
                    check(cyc == c, "R8", "done cycle", 64'(cyc), 64'(c));
                    check(valid == e.v, tg, "valid flags", 64'(valid), 64'(e.v));
                    for (int k = 0; k < 3; k++) begin
                        check(lo_flat[k*32 +: 32] == e.lo[k], tg, $sformatf("slot %0d start", k),
                              64'(lo_flat[k*32 +: 32]), 64'(e.lo[k]));
                        check(hi_flat[k*32 +: 32] == e.hi[k], tg, $sformatf("slot %0d end", k),
                              64'(hi_flat[k*32 +: 32]), 64'(e.hi[k]));
                    end
                    check(ovf == e.ovf, "R6", "overflow flag", 64'(ovf), 64'(e.ovf));
                    @(negedge clk);
                    check(!done, "R8", "done lasts one cycle", 64'(done), 64'd0);
                    check(ovf == e.ovf, "R6", "overflow held", 64'(ovf), 64'(e.ovf));
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        check(0, "R8", "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(valid == 3'b000 && lo_flat == '0 && hi_flat == '0, "R11", "slots after reset",
              64'(valid), 64'd0);
        check(!done && !ovf, "R11", "flags after reset", {62'd0, done, ovf}, 64'd0);

        run_scan(32'hFFFF_FFFF, 32'h003F_FFFF, "R4");   // FA000000-FFFFFFFF, 0-EFFFFFFF
        run_scan(32'h8000_0000, 32'hFFFF_FFFF, "R2");   // F0000000-F0FFFFFF
        run_scan(32'h0000_0002, 32'hFFFF_FFFF, "R3");   // E0000000-EFFFFFFF
        run_scan(32'h0000_0001, 32'hFFFF_FFFF, "R7");   // nothing
        run_scan(32'h0000_0003, 32'hFFFF_FFFF, "R7");   // only position 30
        run_scan(32'hFFFF_FFFF, 32'h0000_0000, "R1");   // mask removes all
        run_scan(32'h0000_D000, 32'hFFFF_FFFF, "R4");   // 0-1FFFFFFF, 30000000-3FFFFFFF
        run_scan(32'h0000_A800, 32'hFFFF_FFFF, "R5");   // three coarse ranges
        run_scan(32'h0001_8000, 32'hFFFF_FFFF, "R5");   // fine end does not join coarse 0
        run_scan(32'h0000_AA00, 32'hFFFF_FFFF, "R6");   // fourth range at position 22
        run_scan(32'h0003_0000, 32'hFFFF_FFFF, "R9", 1'b1, 32'hFFFF_FFFF);
        run_scan(32'h0000_0000, 32'hFFFF_FFFF, "R10");  // all slots stay zero

        finish_run();
    end

endmodule